// File: doc/BRIEF.md
# Scatter-Gather Region DMA Engine

This block is the bus-master half of a disk DMA path. Once a command has been accepted and the device side reports that it is ready to move data, the engine walks a chain of region descriptors in host memory. Each descriptor names a host region (start address, length) and may mark itself as the last one. For every region the engine issues memory bursts that never straddle a page, moving sector data between the device buffer and host memory. A disk write is carried out as memory reads, and a disk read as memory writes.

A job is launched by a one-cycle `start` pulse that carries the descriptor chain pointer, the command's total byte budget and the direction. The engine then waits for the device's ready indication, fetches descriptors one at a time, and meters every burst against the budget. When the memory bus reports busy, it stands off for a fixed number of cycles before trying again. It finishes with a one-cycle `xfer_done` or `xfer_err` pulse, plus an interrupt pulse unless interrupts are masked.

Top module: `sg_dma_engine`

## Requirements
- R1: The first descriptor fetch goes to `table_base` with its two low bits cleared. Every descriptor fetch is an 8-byte read (`mem_write`=0, `mem_len`=8).
- R2: After a descriptor, the next one is fetched from the previous fetch address plus 8. The descriptor layout is: bits 31:0 region base, bits 47:32 byte count, bit 63 last-descriptor flag.
- R3: After `start`, no memory request is made while `dev_dma_ready` is low. The first descriptor request appears in the second cycle after the cycle in which `dev_dma_ready` is sampled high.
- R4: Each data burst length is the smaller of the region bytes still to move and one page, shortened to end exactly at the next page boundary when it would reach or pass it. A region's bursts are contiguous and add up to its byte count.
- R5: A descriptor byte count of 0 means 65536 bytes.
- R6: No request is asserted while `mem_busy` is high. A request blocked by busy is retried every BACKOFF+1 cycles (7 by default) until the bus is free.
- R7: Data bursts use `mem_write` = `to_memory` as latched at `start`.
- R8: When the last region of a flagged-last descriptor completes and the byte budget is exactly used up, `xfer_done` pulses for one cycle and the engine returns to idle, ready for a new job.
- R9: If a burst would exceed the remaining byte budget, the burst is not issued and `xfer_err` pulses.
- R10: If the flagged-last descriptor completes while budget remains, `xfer_err` pulses instead of `xfer_done`.
- R11: `irq` pulses together with `xfer_done` or `xfer_err` when `irq_mask` is low in that completing cycle, and stays low when it is high.
- R12: After reset, `mem_req`, `xfer_done`, `xfer_err` and `irq` are low. A request not yet granted keeps its address and length until grant, unless busy withdraws it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle job launch, accepted when idle |
| table_base | input | 32 | Descriptor chain pointer (low two bits ignored) |
| cmd_bytes | input | CMD_W | Byte budget of the command |
| to_memory | input | 1 | 1: device to memory (memory writes); 0: memory to device |
| dev_dma_ready | input | 1 | Device is in its DMA transfer state |
| irq_mask | input | 1 | Suppresses the completion interrupt |
| mem_req | output | 1 | Memory request, held until grant |
| mem_write | output | 1 | Request is a memory write |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | LEN_W | Request byte length |
| mem_gnt | input | 1 | Request accepted |
| mem_busy | input | 1 | Bus cannot take a request this cycle |
| mem_ack | input | 1 | Accepted request has completed |
| mem_rdata | input | 64 | Descriptor data, valid with `mem_ack` |
| xfer_done | output | 1 | Job finished cleanly (pulse) |
| xfer_err | output | 1 | Job aborted on a budget mismatch (pulse) |
| irq | output | 1 | Completion interrupt (pulse) |

## Verification
A corrupted walk pointer or region offset shows within one request: the next `mem_addr` after a grant lands off the expected fetch address or burst start. A wrong page trim shows as a burst length that differs from the independently computed split, or one that runs past a page boundary. Budget tracking faults surface only at the end of a region, as the wrong choice between `xfer_done` and `xfer_err`. A back-off counter fault moves the retried request off its fixed cycle grid.

// File: rtl/sg_pkg.sv
package sg_pkg;

    localparam int ADDR_W     = 32;
    localparam int DESC_BYTES = 8;
    localparam int COUNT_W    = 16;
    localparam int REGION_W   = COUNT_W + 1;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_START,
        ENG_XFER
    } eng_state_e;

    typedef enum logic [2:0] {
        PH_ARM,
        PH_DESC_REQ,
        PH_DESC_WAIT,
        PH_BURST_REQ,
        PH_BURST_WAIT,
        PH_BACKOFF
    } phase_e;

    typedef struct packed {
        logic                last;
        logic [REGION_W-1:0] bytes;
        logic [ADDR_W-1:0]   base;
    } region_t;

    // Unpack one descriptor word; a zero count stands for the full 64 KiB.
    function automatic region_t unpack_region(input logic [63:0] w);
        region_t r;
        r.base  = w[31:0];
        r.last  = w[63];
        r.bytes = (w[47:32] == '0) ? REGION_W'(1 << COUNT_W)
                                   : {1'b0, w[47:32]};
        return r;
    endfunction

endpackage

// File: rtl/sg_burst_calc.sv
module sg_burst_calc
    import sg_pkg::*;
#(
    parameter int PAGE_BYTES = 8192,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int LEN_W     = PAGE_W + 1
) (
    input  logic [ADDR_W-1:0]   cur_addr,
    input  logic [REGION_W-1:0] remaining,
    output logic [LEN_W-1:0]    burst_len
);
    logic [REGION_W-1:0] capped;
    logic [LEN_W-1:0]    room;

    always_comb begin
        capped = (remaining > REGION_W'(PAGE_BYTES)) ? REGION_W'(PAGE_BYTES)
                                                     : remaining;
        room   = LEN_W'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_W-1:0]};
        if (capped >= REGION_W'(room))
            burst_len = room;
        else
            burst_len = LEN_W'(capped);
    end
endmodule

// File: rtl/sg_backoff_timer.sv
module sg_backoff_timer #(
    parameter int BACKOFF = 6,
    localparam int CNT_W  = (BACKOFF < 2) ? 1 : $clog2(BACKOFF)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expired
);
    logic             running;
    logic [CNT_W-1:0] count;

    assign expired = running && (count == CNT_W'(BACKOFF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= '0;
        end else if (arm) begin
            running <= 1'b1;
            count   <= '0;
        end else if (expired) begin
            running <= 1'b0;
            count   <= '0;
        end else if (running) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sg_cmd_ledger.sv
module sg_cmd_ledger #(
    parameter int CMD_W = 18,
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CMD_W-1:0] load_bytes,
    input  logic             take,
    input  logic [LEN_W-1:0] take_len,
    input  logic [LEN_W-1:0] probe_len,
    output logic             overrun,
    output logic             drains
);
    logic [CMD_W-1:0] left;

    assign overrun = CMD_W'(probe_len) > left;
    assign drains  = CMD_W'(take_len) == left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (load)
            left <= load_bytes;
        else if (take)
            left <= left - CMD_W'(take_len);
    end
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
    import sg_pkg::*;
#(
    parameter int PAGE_BYTES = 8192,
    parameter int BACKOFF    = 6,
    parameter int CMD_W      = 18,
    localparam int LEN_W     = $clog2(PAGE_BYTES) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ADDR_W-1:0]  table_base,
    input  logic [CMD_W-1:0]   cmd_bytes,
    input  logic               to_memory,
    input  logic               dev_dma_ready,
    input  logic               irq_mask,
    output logic               mem_req,
    output logic               mem_write,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    input  logic               mem_gnt,
    input  logic               mem_busy,
    input  logic               mem_ack,
    input  logic [63:0]        mem_rdata,
    output logic               xfer_done,
    output logic               xfer_err,
    output logic               irq
);
    eng_state_e          state;
    phase_e              phase, resume;
    region_t             region;
    logic [ADDR_W-1:0]   desc_ptr;
    logic [REGION_W-1:0] issued;
    logic [LEN_W-1:0]    held_len;
    logic                dir_q;
    logic                done_q, err_q, irq_q;

    logic                desc_phase, burst_phase, xfer_active;
    logic [ADDR_W-1:0]   cur_addr;
    logic [REGION_W-1:0] remaining;
    logic [LEN_W-1:0]    burst_len;
    logic                overrun, drains, bo_expired, bo_arm;
    logic                region_end;

    assign xfer_active = (state == ENG_XFER);
    assign desc_phase  = xfer_active && (phase == PH_DESC_REQ);
    assign burst_phase = xfer_active && (phase == PH_BURST_REQ);
    assign cur_addr    = region.base + ADDR_W'(issued);
    assign remaining   = region.bytes - issued;
    assign region_end  = (issued + REGION_W'(held_len)) == region.bytes;

    assign bo_arm  = mem_busy && (desc_phase || (burst_phase && !overrun));
    assign mem_req = !mem_busy && (desc_phase || (burst_phase && !overrun));
    assign mem_write = burst_phase ? dir_q : 1'b0;
    assign mem_addr  = burst_phase ? cur_addr : desc_ptr;
    assign mem_len   = burst_phase ? burst_len : LEN_W'(DESC_BYTES);

    assign xfer_done = done_q;
    assign xfer_err  = err_q;
    assign irq       = irq_q;

    sg_burst_calc #(.PAGE_BYTES(PAGE_BYTES)) u_calc (
        .cur_addr  (cur_addr),
        .remaining (remaining),
        .burst_len (burst_len)
    );

    sg_backoff_timer #(.BACKOFF(BACKOFF)) u_backoff (
        .clk     (clk),
        .rst     (rst),
        .arm     (bo_arm),
        .expired (bo_expired)
    );

    sg_cmd_ledger #(.CMD_W(CMD_W), .LEN_W(LEN_W)) u_ledger (
        .clk        (clk),
        .rst        (rst),
        .load       (state == ENG_IDLE && start),
        .load_bytes (cmd_bytes),
        .take       (xfer_active && phase == PH_BURST_WAIT && mem_ack),
        .take_len   (held_len),
        .probe_len  (burst_len),
        .overrun    (overrun),
        .drains     (drains)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            phase    <= PH_ARM;
            resume   <= PH_DESC_REQ;
            region   <= '0;
            desc_ptr <= '0;
            issued   <= '0;
            held_len <= '0;
            dir_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        desc_ptr <= {table_base[ADDR_W-1:2], 2'b00};
                        dir_q    <= to_memory;
                        state    <= ENG_START;
                    end
                end
                ENG_START: begin
                    if (dev_dma_ready) begin
                        state <= ENG_XFER;
                        phase <= PH_ARM;
                    end
                end
                ENG_XFER: begin
                    unique case (phase)
                        PH_ARM: phase <= PH_DESC_REQ;
                        PH_DESC_REQ: begin
                            if (mem_busy) begin
                                phase  <= PH_BACKOFF;
                                resume <= PH_DESC_REQ;
                            end else if (mem_gnt) begin
                                phase <= PH_DESC_WAIT;
                            end
                        end
                        PH_DESC_WAIT: begin
                            if (mem_ack) begin
                                region   <= unpack_region(mem_rdata);
                                issued   <= '0;
                                desc_ptr <= desc_ptr + ADDR_W'(DESC_BYTES);
                                phase    <= PH_BURST_REQ;
                            end
                        end
                        PH_BURST_REQ: begin
                            if (overrun) begin
                                state <= ENG_IDLE;
                                err_q <= 1'b1;
                                irq_q <= !irq_mask;
                            end else if (mem_busy) begin
                                phase  <= PH_BACKOFF;
                                resume <= PH_BURST_REQ;
                            end else if (mem_gnt) begin
                                held_len <= burst_len;
                                phase    <= PH_BURST_WAIT;
                            end
                        end
                        PH_BURST_WAIT: begin
                            if (mem_ack) begin
                                issued <= issued + REGION_W'(held_len);
                                if (!region_end) begin
                                    phase <= PH_BURST_REQ;
                                end else if (!region.last) begin
                                    phase <= PH_DESC_REQ;
                                end else begin
                                    state  <= ENG_IDLE;
                                    done_q <= drains;
                                    err_q  <= !drains;
                                    irq_q  <= !irq_mask;
                                end
                            end
                        end
                        PH_BACKOFF: begin
                            if (bo_expired)
                                phase <= resume;
                        end
                        default: phase <= PH_ARM;
                    endcase
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sg_dma_checker.sv
module sg_dma_checker #(
    parameter int PAGE_BYTES = 8192,
    parameter int LEN_W      = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_busy,
    input logic [31:0]      mem_addr,
    input logic [LEN_W-1:0] mem_len,
    input logic             burst_phase,
    input logic             irq_mask,
    input logic             xfer_done,
    input logic             xfer_err,
    input logic             irq
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    a_r4_burst_in_page: assert property (@(posedge clk) disable iff (rst)
        (mem_req && burst_phase) |->
            ((LEN_W+1)'({1'b0, mem_addr[PAGE_W-1:0]}) + (LEN_W+1)'(mem_len)
                <= (LEN_W+1)'(PAGE_BYTES)));

    a_r5_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_len != '0));

    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=>
            (mem_busy || (mem_req && $stable(mem_addr) && $stable(mem_len))));

    a_r10_single_outcome: assert property (@(posedge clk) disable iff (rst)
        !(xfer_done && xfer_err));

    a_r11_irq_follows_end: assert property (@(posedge clk) disable iff (rst)
        irq |-> (xfer_done || xfer_err));

    a_r11_irq_unmasked: assert property (@(posedge clk) disable iff (rst)
        ((xfer_done || xfer_err) && !$past(irq_mask)) |-> irq);
endmodule

bind sg_dma_engine sg_dma_checker #(
    .PAGE_BYTES (PAGE_BYTES),
    .LEN_W      (LEN_W)
) u_sg_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_req     (mem_req),
    .mem_gnt     (mem_gnt),
    .mem_busy    (mem_busy),
    .mem_addr    (mem_addr),
    .mem_len     (mem_len),
    .burst_phase (burst_phase),
    .irq_mask    (irq_mask),
    .xfer_done   (xfer_done),
    .xfer_err    (xfer_err),
    .irq         (irq)
);

// File: tb/tb_sg_dma_engine.sv
module tb_sg_dma_engine;
    localparam int PAGE  = 8192;
    localparam int BOFF  = 6;
    localparam int CMDW  = 18;
    localparam int LENW  = $clog2(PAGE) + 1;
    localparam logic [31:0] TBL = 32'h0000_1000;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 0, to_memory = 0, dev_dma_ready = 0, irq_mask = 0;
    logic [31:0] table_base = '0;
    logic [CMDW-1:0] cmd_bytes = '0;
    logic mem_req, mem_write, mem_gnt, mem_busy = 0, mem_ack;
    logic [31:0] mem_addr;
    logic [LENW-1:0] mem_len;
    logic [63:0] mem_rdata;
    logic xfer_done, xfer_err, irq;

    always #2 clk = ~clk;

    sg_dma_engine #(.PAGE_BYTES(PAGE), .BACKOFF(BOFF), .CMD_W(CMDW)) dut (
        .clk(clk), .rst(rst), .start(start), .table_base(table_base),
        .cmd_bytes(cmd_bytes), .to_memory(to_memory),
        .dev_dma_ready(dev_dma_ready), .irq_mask(irq_mask),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_busy(mem_busy),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .xfer_done(xfer_done), .xfer_err(xfer_err), .irq(irq));

    int n_checks = 0, n_fail = 0, cyc = 0, busy_viol = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // descriptor store and request log
    logic [31:0] d_base [8];
    logic [15:0] d_cnt  [8];
    logic        d_last [8];
    longint lg_addr [64]; longint lg_len [64]; logic lg_wr [64]; int lg_cyc [64];
    int n_lg = 0;
    longint ex_addr [64]; longint ex_len [64]; logic ex_wr [64];
    int n_ex = 0;

    initial begin : mem_model
        int lat; logic pend; logic [63:0] hold; int idx;
        lat = 0; pend = 0; hold = '0;
        mem_gnt = 0; mem_ack = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_gnt = 0; mem_ack = 0;
            if (mem_req && mem_busy) busy_viol++;
            if (pend) begin
                lat--;
                if (lat == 0) begin mem_ack = 1; mem_rdata = hold; pend = 0; end
            end else if (mem_req && !rst) begin
                mem_gnt = 1; pend = 1; lat = 2;
                if (n_lg < 64) begin
                    lg_addr[n_lg] = mem_addr; lg_len[n_lg] = mem_len;
                    lg_wr[n_lg] = mem_write; lg_cyc[n_lg] = cyc; n_lg++;
                end
                hold = '0;
                if (mem_addr >= TBL && mem_addr < TBL + 64) begin
                    idx = int'((mem_addr - TBL) >> 3);
                    hold = {d_last[idx], 15'b0, d_cnt[idx], d_base[idx]};
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input longint a, input longint l, input logic w);
        ex_addr[n_ex] = a; ex_len[n_ex] = l; ex_wr[n_ex] = w; n_ex++;
    endtask

    // independent page split of one region
    task automatic exp_region(input longint base, input longint bytes, input logic w);
        longint a, left, cap, room, l;
        a = base; left = bytes;
        while (left > 0) begin
            cap  = (left > PAGE) ? PAGE : left;
            room = PAGE - (a % PAGE);
            l    = (cap >= room) ? room : cap;
            push_exp(a, l, w);
            a += l; left -= l;
        end
    endtask

    task automatic compare_log(input string req);
        check(n_lg == n_ex, req, n_lg, n_ex);
        for (int i = 0; i < n_ex && i < n_lg; i++) begin
            check(lg_addr[i] == ex_addr[i], req, lg_addr[i], ex_addr[i]);
            check(lg_len[i] == ex_len[i], req, lg_len[i], ex_len[i]);
            check(lg_wr[i] == ex_wr[i], req, longint'(lg_wr[i]), longint'(ex_wr[i]));
        end
    endtask

    int start_cyc;
    task automatic launch(input logic [31:0] tb_in, input int cmd, input logic dir);
        n_lg = 0; n_ex = 0;
        @(posedge clk); #1;
        start_cyc = cyc;
        table_base = tb_in; cmd_bytes = CMDW'(cmd); to_memory = dir; start = 1;
        @(posedge clk); #1;
        start = 0;
    endtask

    // returns 1 done, 2 error, 0 timeout; also irq seen
    task automatic wait_end(output int res, output logic irq_seen);
        res = 0; irq_seen = 0;
        for (int i = 0; i < 2000 && res == 0; i++) begin
            @(negedge clk);
            if (xfer_done) res = 1;
            if (xfer_err)  res = 2;
            if (xfer_done || xfer_err) irq_seen = irq;
        end
    endtask

    task automatic t_reset;
        check(mem_req == 0, "R12 reset req", mem_req, 0);
        check(xfer_done == 0 && xfer_err == 0, "R12 reset done/err", {xfer_done, xfer_err}, 0);
        check(irq == 0, "R12 reset irq", irq, 0);
    endtask

    task automatic t_single;
        int r; logic iq;
        d_base[0] = 32'h0002_0000; d_cnt[0] = 16'd1024; d_last[0] = 1;
        dev_dma_ready = 1; irq_mask = 0;
        launch(TBL | 32'h3, 1024, 1'b1);
        wait_end(r, iq);
        push_exp(TBL, 8, 0);           // R1 masked pointer, 8-byte read
        exp_region(32'h0002_0000, 1024, 1); // R7 memory-write direction
        compare_log("R1/R7 single");
        check(r == 1, "R8 done", r, 1);
        check(iq == 1, "R11 irq unmasked", iq, 1);
        check(lg_cyc[0] == start_cyc + 3, "R3 fetch latency", lg_cyc[0], start_cyc + 3);
    endtask

    task automatic t_page_split;
        int r; logic iq;
        d_base[0] = 32'h0002_1F00; d_cnt[0] = 16'h3000; d_last[0] = 1;
        launch(TBL, 'h3000, 1'b0);
        wait_end(r, iq);
        push_exp(TBL, 8, 0);
        exp_region(32'h0002_1F00, 'h3000, 0);
        compare_log("R4 page split");
        check(n_lg == 4, "R4 burst count", n_lg, 4);
        check(r == 1, "R8 done split", r, 1);
    endtask

    task automatic t_chain;
        int r; logic iq;
        d_base[0] = 32'h0004_0000; d_cnt[0] = 16'd512;  d_last[0] = 0;
        d_base[1] = 32'h0004_5F00; d_cnt[1] = 16'd1536; d_last[1] = 0;
        d_base[2] = 32'h0005_0000; d_cnt[2] = 16'd1024; d_last[2] = 1;
        launch(TBL, 3072, 1'b1);
        wait_end(r, iq);
        push_exp(TBL, 8, 0);      exp_region(32'h0004_0000, 512, 1);
        push_exp(TBL + 8, 8, 0);  exp_region(32'h0004_5F00, 1536, 1);
        push_exp(TBL + 16, 8, 0); exp_region(32'h0005_0000, 1024, 1);
        compare_log("R2 chain walk");
        check(r == 1, "R8 done chain", r, 1);
    endtask

    task automatic t_zero_count;
        int r; logic iq;
        d_base[0] = 32'h0008_0000; d_cnt[0] = 16'd0; d_last[0] = 1;
        launch(TBL, 65536, 1'b0);
        wait_end(r, iq);
        push_exp(TBL, 8, 0);
        exp_region(32'h0008_0000, 65536, 0);
        compare_log("R5 zero count");
        check(r == 1, "R5 done 64KiB", r, 1);
    endtask

    task automatic t_overrun;
        int r; logic iq;
        d_base[0] = 32'h0003_0000; d_cnt[0] = 16'd2048; d_last[0] = 1;
        irq_mask = 1;
        launch(TBL, 1024, 1'b1);
        wait_end(r, iq);
        check(r == 2, "R9 overrun error", r, 2);
        check(n_lg == 1, "R9 no burst issued", n_lg, 1);
        check(iq == 0, "R11 irq masked", iq, 0);
        irq_mask = 0;
    endtask

    task automatic t_underrun;
        int r; logic iq;
        d_base[0] = 32'h0003_0000; d_cnt[0] = 16'd512; d_last[0] = 1;
        launch(TBL, 1024, 1'b0);
        wait_end(r, iq);
        check(r == 2, "R10 budget left error", r, 2);
        check(n_lg == 2, "R10 one burst", n_lg, 2);
        check(iq == 1, "R11 irq on error", iq, 1);
    endtask

    task automatic t_wait_ready;
        int r, rc; logic iq;
        d_base[0] = 32'h0002_0000; d_cnt[0] = 16'd512; d_last[0] = 1;
        dev_dma_ready = 0;
        launch(TBL, 512, 1'b1);
        repeat (20) @(posedge clk);
        #1;
        check(n_lg == 0, "R3 no request before ready", n_lg, 0);
        dev_dma_ready = 1; rc = cyc;
        wait_end(r, iq);
        check(n_lg > 0 && lg_cyc[0] == rc + 2, "R3 request after ready", lg_cyc[0], rc + 2);
        check(r == 1, "R3 done after ready", r, 1);
    endtask

    task automatic t_busy;
        int r, first, exp_cyc, gap; logic iq;
        d_base[0] = 32'h0002_0000; d_cnt[0] = 16'd1024; d_last[0] = 1;
        mem_busy = 1;
        launch(TBL, 1024, 1'b1);
        repeat (11) @(posedge clk);
        #1;
        mem_busy = 0;
        first = start_cyc + 3;
        gap = cyc - first;
        exp_cyc = first + ((gap + BOFF) / (BOFF + 1)) * (BOFF + 1);
        wait_end(r, iq);
        check(lg_cyc[0] == exp_cyc, "R6 retry grid", lg_cyc[0], exp_cyc);
        check(busy_viol == 0, "R6 no request while busy", busy_viol, 0);
        check(r == 1, "R6 done after retry", r, 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 8; i++) begin d_base[i] = '0; d_cnt[i] = '0; d_last[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        t_reset;
        t_single;
        t_page_split;
        t_chain;
        t_zero_count;
        t_overrun;
        t_underrun;
        t_wait_ready;
        t_busy;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule